// File: doc/BRIEF.md
# SPI Master Shift Engine with Multi-Master Fault Detection

This block moves one byte at a time over a four-wire serial link as the clock-driving side. Software loads a set of configuration fields with a single write strobe: master enable, clock idle level, clock phase, bit order, slave-select drive and fault-check options, single-pin data mode with its direction, and interrupt enable. A 3-bit prescale and a 4-bit exponent set the serial clock rate. Writing a byte to the data port starts an 8-bit exchange. The received byte is then presented on `rxData`.

Each driven pin has its own output-enable, so the pin can fall back to being an input. If another master pulls the select line low while this block is watching it, the block does the following in one step:
- it leaves master mode and releases every pin it drives;
- it abandons any exchange in flight;
- it raises a sticky fault flag.

Rewriting a timing- or framing-related field while an exchange is in flight also abandons that exchange.

Top module: `spi_mf_master`

## Requirements
- R1: Define H = (prescale+1) × 2^exponent clocks. After the clock edge that accepts a data write, the serial clock toggles 16 times. Toggle k happens k×H clock edges after the accepting edge. When no exchange is running, `sckOut` rests at the configured idle level.
- R2: `ssOe` is 1 exactly when master mode is on, fault checking is enabled and select drive is enabled. In that case `ssOut` is low from the accepting edge up to the edge of the 16th serial clock toggle, and high at all other times.
- R3: Fault condition: master mode is on, fault checking is enabled, select drive is off, and `ssIn` is low at a clock edge. After that edge `masterMode`, `sckOe`, `mosiOe` and `ssOe` are all 0 and `modeFault` is 1. Reset leaves master mode off.
- R4: A fault during an exchange ends it at once. `xferDone` is not set and the clock returns to its idle level.
- R5: `irq` equals interrupt-enable AND (`modeFault` OR `xferDone`).
- R6: `modeFault` clears only on a configuration write that comes after a `statusRd` pulse taken while the flag was set. A configuration write on its own leaves the flag set.
- R7: A configuration write during an exchange aborts it if it changes any of these: idle level, phase, bit order, select drive, fault enable, single-pin mode, prescale or exponent. It also aborts if it changes the pin direction while single-pin mode is on, or if it clears master mode. An abort leaves `xferDone` low and `ssOut` high. A write that repeats the current values does not abort.
- R8: With single-pin mode off, `mosiOe` follows master mode and received bits come from `misoIn`. With it on, `mosiOe` is master mode AND the direction bit, and received bits come from `mosiIn`.
- R9: With phase 0, bit 0 of the sequence is on `mosiOut` before the first toggle. Odd toggles sample and even toggles advance the output. With phase 1, odd toggles from the third on advance the output and even toggles sample.
- R10: With bit-order 1 the data goes least significant bit first, otherwise most significant bit first. `rxData` holds the sampled bits in their proper positions whichever order is used.
- R11: `xferDone` rises on the 16th toggle and clears when the next exchange is accepted. A data write is ignored while an exchange is running or while master mode is off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low reset |
| ctrlWe | input | 1 | Loads all cfg* fields |
| cfgMaster | input | 1 | Master mode enable |
| cfgCpol | input | 1 | Serial clock idle level |
| cfgCpha | input | 1 | Clock phase select |
| cfgLsbFirst | input | 1 | Bit order, 1 = LSB first |
| cfgSsDrive | input | 1 | Select pin driven by block |
| cfgFaultEn | input | 1 | Select pin used for fault check/drive |
| cfgOnePin | input | 1 | Single bidirectional data pin |
| cfgPinDir | input | 1 | Single-pin direction, 1 = output |
| cfgIrqEn | input | 1 | Interrupt enable |
| cfgPre | input | 3 | Clock prescale |
| cfgRate | input | 4 | Clock exponent |
| dataWe | input | 1 | Data write, starts an exchange |
| dataIn | input | 8 | Byte to send |
| statusRd | input | 1 | Status read pulse (fault clear step 1) |
| rxData | output | 8 | Last received byte |
| masterMode | output | 1 | Current master mode |
| modeFault | output | 1 | Sticky fault flag |
| xferDone | output | 1 | Exchange complete |
| irq | output | 1 | Interrupt request |
| sckOut | output | 1 | Serial clock value |
| sckOe | output | 1 | Serial clock drive enable |
| mosiOut | output | 1 | Data out value |
| mosiOe | output | 1 | Data out drive enable |
| mosiIn | input | 1 | Data pin readback (single-pin mode) |
| misoIn | input | 1 | Data in |
| ssOut | output | 1 | Select value |
| ssOe | output | 1 | Select drive enable |
| ssIn | input | 1 | Select pin readback |

## Verification
If the toggle or prescale counter slips, `sckOut` moves off the k×H grid on the first toggle that is late or early, which is at most H clocks after a start. If the phase or bit-order decode is wrong, `mosiOut` differs within one half period, and `rxData` is corrupt when the byte completes. If the master, fault or abort state is wrong, the pin enables and `modeFault` show it one clock after the offending `ssIn` level or configuration write. The bench therefore compares every output on every clock against a behavioural timeline.

// File: rtl/spi_mf_pkg.sv
package spi_mf_pkg;
  localparam int PRE_W  = 3;
  localparam int RATE_W = 4;
  localparam int DATA_W = 8;
  localparam int CNT_W  = PRE_W + 1 + (1 << RATE_W) - 1;
  localparam int EDGE_N = 2 * DATA_W;
  localparam int EDGE_W = $clog2(EDGE_N + 1);

  typedef struct packed {
    logic              cpol;
    logic              cpha;
    logic              lsbFirst;
    logic              ssDrive;
    logic              faultEn;
    logic              onePin;
    logic              pinDir;
    logic              irqEn;
    logic [PRE_W-1:0]  pre;
    logic [RATE_W-1:0] rate;
  } cfg_t;

  typedef struct packed {
    logic load;
    logic shiftTx;
    logic sampleRx;
  } strobe_t;
endpackage

// File: rtl/spi_mf_ctrl.sv
module spi_mf_ctrl
  import spi_mf_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    ctrlWe,
  input  cfg_t    cfgIn,
  input  logic    masterIn,
  input  logic    dataWe,
  input  logic    statusRd,
  input  logic    ssIn,
  output cfg_t    cfgQ,
  output logic    masterQ,
  output logic    busyQ,
  output logic    sckOut,
  output logic    modfQ,
  output logic    doneQ,
  output strobe_t strobe
);
  logic [CNT_W-1:0]  baudCnt;
  logic [CNT_W-1:0]  halfDiv;
  logic [EDGE_W-1:0] edgeCnt;
  logic              phaseQ;
  logic              armQ;
  logic              fault, cfgDiff, abortX, start, tick, lastEdge, sampleEdge;

  assign halfDiv = CNT_W'({1'b0, cfgQ.pre} + 1'b1) << cfgQ.rate;
  assign tick    = busyQ && (baudCnt == halfDiv - CNT_W'(1));
  assign lastEdge = tick && (edgeCnt == EDGE_W'(EDGE_N - 1));

  // another master pulling select low
  assign fault = masterQ && cfgQ.faultEn && !cfgQ.ssDrive && !ssIn;

  assign cfgDiff = ctrlWe && (
      (cfgIn.cpol     != cfgQ.cpol)     || (cfgIn.cpha    != cfgQ.cpha)    ||
      (cfgIn.lsbFirst != cfgQ.lsbFirst) || (cfgIn.ssDrive != cfgQ.ssDrive) ||
      (cfgIn.faultEn  != cfgQ.faultEn)  || (cfgIn.onePin  != cfgQ.onePin)  ||
      (cfgIn.pre      != cfgQ.pre)      || (cfgIn.rate    != cfgQ.rate)    ||
      (cfgQ.onePin && (cfgIn.pinDir != cfgQ.pinDir)));

  assign abortX = busyQ && (fault || cfgDiff || (ctrlWe && !masterIn));
  assign start  = dataWe && !busyQ && masterQ && !fault;

  // odd toggles have edgeCnt[0]==0 before increment
  assign sampleEdge      = tick && (edgeCnt[0] == cfgQ.cpha);
  assign strobe.load     = start;
  assign strobe.sampleRx = sampleEdge;
  assign strobe.shiftTx  = tick && !sampleEdge && !lastEdge &&
                           !(cfgQ.cpha && edgeCnt == '0);

  assign sckOut = cfgQ.cpol ^ phaseQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfgQ    <= '0;
      masterQ <= 1'b0;
      busyQ   <= 1'b0;
      baudCnt <= '0;
      edgeCnt <= '0;
      phaseQ  <= 1'b0;
      modfQ   <= 1'b0;
      armQ    <= 1'b0;
      doneQ   <= 1'b0;
    end else begin
      if (ctrlWe) cfgQ <= cfgIn;

      if (fault)       masterQ <= 1'b0;
      else if (ctrlWe) masterQ <= masterIn;

      if (abortX)        busyQ <= 1'b0;
      else if (start)    busyQ <= 1'b1;
      else if (lastEdge) busyQ <= 1'b0;

      if (!busyQ || abortX || tick) baudCnt <= '0;
      else                          baudCnt <= baudCnt + CNT_W'(1);

      if (!busyQ || abortX) begin
        edgeCnt <= '0;
        phaseQ  <= 1'b0;
      end else if (tick) begin
        edgeCnt <= edgeCnt + EDGE_W'(1);
        phaseQ  <= ~phaseQ;
      end

      if (start)                    doneQ <= 1'b0;
      else if (lastEdge && !abortX) doneQ <= 1'b1;

      if (fault)               modfQ <= 1'b1;
      else if (ctrlWe && armQ) modfQ <= 1'b0;

      if (ctrlWe)                 armQ <= 1'b0;
      else if (statusRd && modfQ) armQ <= 1'b1;
    end
  end
endmodule

// File: rtl/spi_mf_dpath.sv
module spi_mf_dpath
  import spi_mf_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strobe,
  input  logic              lsbFirst,
  input  logic              onePin,
  input  logic [DATA_W-1:0] txData,
  input  logic              misoIn,
  input  logic              mosiIn,
  output logic              txBit,
  output logic [DATA_W-1:0] rxData
);
  logic [DATA_W-1:0] txSr;
  logic [DATA_W-1:0] rxSr;
  logic              inBit;

  assign inBit  = onePin ? mosiIn : misoIn;
  assign txBit  = lsbFirst ? txSr[0] : txSr[DATA_W-1];
  assign rxData = rxSr;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txSr <= '0;
      rxSr <= '0;
    end else begin
      if (strobe.load)
        txSr <= txData;
      else if (strobe.shiftTx)
        txSr <= lsbFirst ? {1'b0, txSr[DATA_W-1:1]} : {txSr[DATA_W-2:0], 1'b0};

      if (strobe.sampleRx)
        rxSr <= lsbFirst ? {inBit, rxSr[DATA_W-1:1]} : {rxSr[DATA_W-2:0], inBit};
    end
  end
endmodule

// File: rtl/spi_mf_master.sv
module spi_mf_master
  import spi_mf_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              ctrlWe,
  input  logic              cfgMaster,
  input  logic              cfgCpol,
  input  logic              cfgCpha,
  input  logic              cfgLsbFirst,
  input  logic              cfgSsDrive,
  input  logic              cfgFaultEn,
  input  logic              cfgOnePin,
  input  logic              cfgPinDir,
  input  logic              cfgIrqEn,
  input  logic [PRE_W-1:0]  cfgPre,
  input  logic [RATE_W-1:0] cfgRate,
  input  logic              dataWe,
  input  logic [DATA_W-1:0] dataIn,
  input  logic              statusRd,
  output logic [DATA_W-1:0] rxData,
  output logic              masterMode,
  output logic              modeFault,
  output logic              xferDone,
  output logic              irq,
  output logic              sckOut,
  output logic              sckOe,
  output logic              mosiOut,
  output logic              mosiOe,
  input  logic              mosiIn,
  input  logic              misoIn,
  output logic              ssOut,
  output logic              ssOe,
  input  logic              ssIn
);
  cfg_t    cfgIn, cfgQ;
  strobe_t strobe;
  logic    busyQ;

  assign cfgIn = '{cpol: cfgCpol, cpha: cfgCpha, lsbFirst: cfgLsbFirst,
                   ssDrive: cfgSsDrive, faultEn: cfgFaultEn, onePin: cfgOnePin,
                   pinDir: cfgPinDir, irqEn: cfgIrqEn, pre: cfgPre, rate: cfgRate};

  spi_mf_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .ctrlWe(ctrlWe), .cfgIn(cfgIn), .masterIn(cfgMaster),
    .dataWe(dataWe), .statusRd(statusRd), .ssIn(ssIn), .cfgQ(cfgQ),
    .masterQ(masterMode), .busyQ(busyQ), .sckOut(sckOut), .modfQ(modeFault),
    .doneQ(xferDone), .strobe(strobe)
  );

  spi_mf_dpath u_dpath (
    .clk(clk), .rstN(rstN), .strobe(strobe), .lsbFirst(cfgQ.lsbFirst),
    .onePin(cfgQ.onePin), .txData(dataIn), .misoIn(misoIn), .mosiIn(mosiIn),
    .txBit(mosiOut), .rxData(rxData)
  );

  assign sckOe  = masterMode;
  assign mosiOe = masterMode && (!cfgQ.onePin || cfgQ.pinDir);
  assign ssOe   = masterMode && cfgQ.faultEn && cfgQ.ssDrive;
  assign ssOut  = !busyQ;
  assign irq    = cfgQ.irqEn && (modeFault || xferDone);
endmodule

// File: rtl/spi_mf_checks.sv
module spi_mf_checks (
  input logic clk,
  input logic rstN,
  input logic sckOut,
  input logic sckOe,
  input logic mosiOe,
  input logic ssOut,
  input logic ssOe,
  input logic modeFault,
  input logic xferDone,
  input logic irq,
  input logic dataWe,
  input logic masterMode,
  input logic busy,
  input logic cpol,
  input logic irqEn
);
  p_sck_idle_r1: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> (sckOut == cpol));

  p_ss_start_r2: assert property (@(posedge clk) disable iff (!rstN)
    (ssOe && $fell(ssOut)) |-> $past(dataWe));

  p_fault_release_r3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(modeFault) |-> (!masterMode && !sckOe && !mosiOe && !ssOe));

  p_fault_abort_r4: assert property (@(posedge clk) disable iff (!rstN)
    $rose(modeFault) |-> !busy);

  p_irq_fault_r5: assert property (@(posedge clk) disable iff (!rstN)
    (modeFault && irqEn) |-> irq);

  p_done_end_r11: assert property (@(posedge clk) disable iff (!rstN)
    $rose(xferDone) |-> ($past(busy) && !busy));

  p_slave_nostart_r11: assert property (@(posedge clk) disable iff (!rstN)
    (!masterMode && dataWe) |=> !busy);
endmodule

bind spi_mf_master spi_mf_checks u_chk (
  .clk(clk), .rstN(rstN), .sckOut(sckOut), .sckOe(sckOe), .mosiOe(mosiOe),
  .ssOut(ssOut), .ssOe(ssOe), .modeFault(modeFault), .xferDone(xferDone),
  .irq(irq), .dataWe(dataWe), .masterMode(masterMode), .busy(busyQ),
  .cpol(cfgQ.cpol), .irqEn(cfgQ.irqEn)
);

// File: tb/sim_spi_mf_master.sv
`timescale 1ns/1ps
module sim_spi_mf_master;
  logic clk = 1'b0, rstN = 1'b0;
  logic ctrlWe = 0, cfgMaster = 0, cfgCpol = 0, cfgCpha = 0, cfgLsbFirst = 0;
  logic cfgSsDrive = 0, cfgFaultEn = 0, cfgOnePin = 0, cfgPinDir = 0, cfgIrqEn = 0;
  logic [2:0] cfgPre = 0;
  logic [3:0] cfgRate = 0;
  logic dataWe = 0, statusRd = 0, ssIn = 1, misoIn = 0, mosiIn = 0;
  logic [7:0] dataIn = 0;
  logic [7:0] rxData;
  logic masterMode, modeFault, xferDone, irq, sckOut, sckOe, mosiOut, mosiOe, ssOut, ssOe;

  int vectors = 0, fails = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  spi_mf_master u0 (.*);

  // behavioural timeline
  logic mMaster, mCpol, mCpha, mLsb, mSsDrive, mFaultEn, mOnePin, mPinDir, mIrqEn;
  logic mBusy, mModf, mArm, mDone;
  int mPre, mRate, mCnt, mK;
  logic [7:0] mTx, slaveByte = 8'h00;

  function automatic int bitIdx(int k, logic cpha);
    int i;
    i = cpha ? ((k == 0) ? 0 : (k - 1) / 2) : k / 2;
    return (i > 7) ? 7 : i;
  endfunction

  function automatic logic seqBit(logic [7:0] v, int idx, logic lsb);
    return lsb ? v[idx] : v[7 - idx];
  endfunction

  always @(posedge clk) begin
    logic fault, chg, aborted, oldBusy, oldMaster, oldModf, sb;
    int h;
    if (!rstN) begin
      {mMaster, mCpol, mCpha, mLsb, mSsDrive, mFaultEn, mOnePin, mPinDir, mIrqEn} = '0;
      {mBusy, mModf, mArm, mDone} = '0;
      mPre = 0; mRate = 0; mCnt = 0; mK = 0; mTx = 0;
    end else begin
      fault = mMaster && mFaultEn && !mSsDrive && !ssIn;
      h = (mPre + 1) << mRate;
      oldBusy = mBusy; oldMaster = mMaster; oldModf = mModf;
      chg = ctrlWe && (cfgCpol != mCpol || cfgCpha != mCpha || cfgLsbFirst != mLsb ||
            cfgSsDrive != mSsDrive || cfgFaultEn != mFaultEn || cfgOnePin != mOnePin ||
            int'(cfgPre) != mPre || int'(cfgRate) != mRate || (mOnePin && cfgPinDir != mPinDir));
      aborted = mBusy && (fault || chg || (ctrlWe && !cfgMaster));
      if (aborted) mBusy = 0;
      if (fault) mModf = 1; else if (ctrlWe && mArm) mModf = 0;
      if (ctrlWe) mArm = 0; else if (statusRd && oldModf) mArm = 1;
      if (mBusy) begin
        mCnt++;
        if (mCnt == h) begin
          mCnt = 0; mK++;
          if (mK == 16) begin mBusy = 0; mDone = 1; end
        end
      end
      if (dataWe && !oldBusy && oldMaster && !fault) begin
        mBusy = 1; mCnt = 0; mK = 0; mTx = dataIn; mDone = 0;
      end
      if (ctrlWe) begin
        mCpol = cfgCpol; mCpha = cfgCpha; mLsb = cfgLsbFirst; mSsDrive = cfgSsDrive;
        mFaultEn = cfgFaultEn; mOnePin = cfgOnePin; mPinDir = cfgPinDir; mIrqEn = cfgIrqEn;
        mPre = int'(cfgPre); mRate = int'(cfgRate);
      end
      if (fault) mMaster = 0; else if (ctrlWe) mMaster = cfgMaster;
      if (!mBusy) begin mCnt = 0; mK = 0; end
    end
    sb = seqBit(slaveByte, bitIdx(mK, mCpha), mLsb);
    misoIn <= sb;
    mosiIn <= ~sb;
  end

  task automatic chk(string tag, int act, int exp);
    vectors++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rstN && !finished) begin
      chk("R1 sckOut", sckOut, mCpol ^ (mBusy && (mK % 2 == 1)));
      chk("R2 ssOe", ssOe, mMaster && mFaultEn && mSsDrive);
      if (ssOe) chk("R2 ssOut", ssOut, !mBusy);
      chk("R3 masterMode", masterMode, mMaster);
      chk("R3 sckOe", sckOe, mMaster);
      chk("R8 mosiOe", mosiOe, mMaster && (!mOnePin || mPinDir));
      if (mBusy) chk("R9 R10 mosiOut", mosiOut, seqBit(mTx, bitIdx(mK, mCpha), mLsb));
      chk("R6 modeFault", modeFault, mModf);
      chk("R11 xferDone", xferDone, mDone);
      chk("R5 irq", irq, mIrqEn && (mModf || mDone));
    end
  end

  task automatic setCfg(logic ms, logic cp, logic ph, logic lf, logic sd, logic fe,
                        logic op, logic pd, logic ie, int pre, int rate);
    @(negedge clk);
    cfgMaster = ms; cfgCpol = cp; cfgCpha = ph; cfgLsbFirst = lf; cfgSsDrive = sd;
    cfgFaultEn = fe; cfgOnePin = op; cfgPinDir = pd; cfgIrqEn = ie;
    cfgPre = 3'(pre); cfgRate = 4'(rate); ctrlWe = 1;
    @(negedge clk);
    ctrlWe = 0;
  endtask

  task automatic startXfer(logic [7:0] d, logic [7:0] s);
    @(negedge clk);
    slaveByte = s; dataIn = d; dataWe = 1;
    @(negedge clk);
    dataWe = 0;
  endtask

  task automatic waitDone(string tag, logic [7:0] expRx);
    for (int i = 0; i < 5000; i++) begin
      @(negedge clk);
      if (xferDone) break;
    end
    chk({tag, " done"}, xferDone, 1);
    chk({tag, " rxData"}, rxData, expRx);
  endtask

  initial begin
    #(20 * 150000);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog expired actual=hung expected=finish");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      finished = 1;
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    chk("R3 reset master", masterMode, 0);
    chk("R2 reset ssOe", ssOe, 0);
    chk("R11 reset done", xferDone, 0);

    // phase 0, idle low, MSB first, fastest clock
    setCfg(1, 0, 0, 0, 1, 1, 0, 0, 0, 0, 0);
    startXfer(8'hA5, 8'h3C);
    waitDone("R10 msb cpha0", 8'h3C);

    // phase 1, idle high, LSB first, H=6, write during transfer ignored (R11)
    setCfg(1, 1, 1, 1, 1, 1, 0, 0, 1, 2, 1);
    startXfer(8'h96, 8'hC3);
    repeat (20) @(negedge clk);
    dataIn = 8'hFF; dataWe = 1;
    @(negedge clk);
    dataWe = 0;
    waitDone("R11 busy write ignored", 8'hC3);
    chk("R5 done irq", irq, 1);

    // single-pin mode samples mosiIn (driven inverted) R8
    setCfg(1, 0, 1, 0, 1, 1, 1, 1, 0, 1, 0);
    startXfer(8'h5A, 8'h81);
    waitDone("R8 one pin", 8'h7E);
    setCfg(1, 0, 1, 0, 1, 1, 1, 0, 0, 1, 0);
    chk("R8 pin input", mosiOe, 0);

    // abort by configuration change R7
    setCfg(1, 0, 0, 0, 1, 1, 0, 0, 0, 1, 1);
    startXfer(8'h0F, 8'hF0);
    repeat (10) @(negedge clk);
    setCfg(1, 0, 0, 0, 1, 1, 0, 0, 0, 1, 1);
    chk("R7 same write no abort", ssOut, 0);
    repeat (8) @(negedge clk);
    setCfg(1, 0, 1, 0, 1, 1, 0, 0, 0, 1, 1);
    repeat (2) @(negedge clk);
    chk("R7 abort done", xferDone, 0);
    chk("R7 abort ss", ssOut, 1);
    chk("R7 abort sck", sckOut, 0);
    startXfer(8'h24, 8'h6B);
    waitDone("R9 cpha1 after abort", 8'h6B);

    // mode fault R3 R4 R5 R6
    setCfg(1, 0, 0, 0, 0, 1, 0, 0, 1, 0, 2);
    startXfer(8'h33, 8'h55);
    repeat (12) @(negedge clk);
    ssIn = 0;
    repeat (2) @(negedge clk);
    chk("R3 fault master", masterMode, 0);
    chk("R3 fault sckOe", sckOe, 0);
    chk("R4 fault no done", xferDone, 0);
    chk("R4 fault sck idle", sckOut, 0);
    chk("R5 fault irq", irq, 1);
    dataIn = 8'h11; dataWe = 1;
    @(negedge clk);
    dataWe = 0;
    repeat (4) @(negedge clk);
    chk("R11 slave write ignored", xferDone, 0);
    ssIn = 1;
    setCfg(1, 0, 0, 0, 0, 1, 0, 0, 1, 0, 2);
    chk("R6 write alone keeps flag", modeFault, 1);
    @(negedge clk);
    statusRd = 1;
    @(negedge clk);
    statusRd = 0;
    setCfg(1, 0, 0, 0, 0, 1, 0, 0, 1, 0, 2);
    chk("R6 read then write clears", modeFault, 0);
    startXfer(8'hC9, 8'h2D);
    waitDone("R1 recovery", 8'h2D);

    repeat (4) @(negedge clk);
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule